// File: doc/BRIEF.md
# Zero-Input Signal Detector

This block watches a serial audio link made of a data line, a bit clock and a frame clock running at the sample rate. It raises a single status flag that means "no signal present". The flag is high from reset until the first data bit sampled high. It rises again once the data line has carried only low bits for a long run of whole frames. The default run is 2^14 frames, which is about 0.37 s at 44.1 kHz. The block does not decode samples. It looks only at the raw bit values taken at bit clock rising edges.

All three link inputs are asynchronous to the system clock. They pass through synchronizer chains of equal depth, so a data bit and its bit clock edge stay aligned. Rising edges are then detected in the system clock domain. The interface has no valid/ready handshake and no back-pressure. The link pins and the flag are plain level signals, and the flag may be read in any cycle.

Top module: `zero_run_detector`

## Requirements
- R1: After reset the flag `no_signal_o` is 1. It stays 1 until a data bit sampled high arrives, whatever number of all-low frames come first.
- R2: The data line is taken into account only at bit clock rising edges. A high level on `sdata_i` that falls back low before the next bit clock rise has no effect on the flag.
- R3: A data bit sampled high drops the flag to 0. The flag falls on the third rising clock edge after the bit clock rise is present at the pin, and not earlier.
- R4: A frame clock rising edge advances the zero-run count by one only if no high bit was sampled since the previous frame clock rise. The flag goes to 1 when the count reaches 2^RUN_LOG2.
- R5: The count saturates at 2^RUN_LOG2, so the flag stays 1 through any further all-low frames.
- R6: A single high bit anywhere in a frame restarts the run. After it, a full 2^RUN_LOG2 qualifying frame edges are again needed before the flag returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial audio data line, asynchronous |
| bclk_i | input | 1 | Bit clock; data is sampled at its rising edge |
| fclk_i | input | 1 | Frame clock at the sample rate; its rising edge closes a frame |
| no_signal_o | output | 1 | 1 = no signal present (reset state or long low run) |

## Verification
With two synchronizer stages, a change on a pin is registered by the third rising clock edge after it is driven. A high bit therefore lowers the flag on that third edge, and a frame edge that completes the run raises the flag on that same edge. The bench samples the flag one time unit after the second and after the third edge following a high bit's bit clock rise. At the second edge it expects the old value, and at the third edge it expects the new value. All other expected flag values are queued six cycles after each frame ends. By then every pipeline stage has settled, and no frame clock edge has yet arrived to change the result.

// File: rtl/zd_pkg.sv
package zd_pkg;
  // Link lines in the order they are carried through the synchronizer.
  typedef struct packed {
    logic data;
    logic bclk;
    logic fclk;
  } zd_lines_t;

  localparam int unsigned ZD_LINES = $bits(zd_lines_t);
endpackage

// File: rtl/zd_sync.sv
module zd_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/zd_edge.sv
module zd_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_rise
      assign rise_o[i] = level_i[i] & ~prev_q[i];
    end
  endgenerate
endmodule

// File: rtl/zd_run_counter.sv
module zd_run_counter #(
  parameter int unsigned RUN_LOG2 = 14,
  localparam int unsigned CNT_W   = RUN_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             frame_edge_i,
  output logic [CNT_W-1:0] count_o,
  output logic             no_signal_o
);
  localparam logic [CNT_W-1:0] LIMIT = {1'b1, {RUN_LOG2{1'b0}}};

  logic [CNT_W-1:0] count_q;
  logic             frame_hit_q;

  // Reset loads the saturated value: no signal until data is seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q     <= LIMIT;
      frame_hit_q <= 1'b0;
    end else if (hit_i) begin
      count_q     <= '0;
      frame_hit_q <= 1'b1;
    end else if (frame_edge_i) begin
      frame_hit_q <= 1'b0;
      if (!frame_hit_q && (count_q != LIMIT)) count_q <= count_q + CNT_W'(1);
    end
  end

  assign count_o     = count_q;
  assign no_signal_o = (count_q == LIMIT);
endmodule

// File: rtl/zero_run_detector.sv
module zero_run_detector #(
  parameter int unsigned RUN_LOG2    = 14,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = RUN_LOG2 + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdata_i,
  input  logic bclk_i,
  input  logic fclk_i,
  output logic no_signal_o
);
  import zd_pkg::*;

  zd_lines_t        lines_raw;
  zd_lines_t        lines_s;
  logic [1:0]       rises;
  logic             hit;
  logic             frame_edge;
  logic [CNT_W-1:0] run_count;

  assign lines_raw = '{data: sdata_i, bclk: bclk_i, fclk: fclk_i};

  zd_sync #(.WIDTH(ZD_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (lines_raw),
    .sync_o  (lines_s)
  );

  zd_edge #(.WIDTH(2)) i_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i ({lines_s.fclk, lines_s.bclk}),
    .rise_o  (rises)
  );

  assign hit        = rises[0] & lines_s.data;
  assign frame_edge = rises[1];

  zd_run_counter #(.RUN_LOG2(RUN_LOG2)) i_run (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_i        (hit),
    .frame_edge_i (frame_edge),
    .count_o      (run_count),
    .no_signal_o  (no_signal_o)
  );
endmodule

// File: rtl/zero_run_detector_chk.sv
module zero_run_detector_chk #(
  parameter int unsigned RUN_LOG2 = 14,
  localparam int unsigned CNT_W   = RUN_LOG2 + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hit,
  input logic             frame_edge,
  input logic [CNT_W-1:0] count,
  input logic             no_signal
);
  localparam logic [CNT_W-1:0] LIMIT = {1'b1, {RUN_LOG2{1'b0}}};

  AST_HIT_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !no_signal); // R3

  AST_RISE_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_signal) |-> $past(frame_edge)); // R4

  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !frame_edge) |=> $stable(count)); // R2

  AST_SATURATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (no_signal && !hit) |=> no_signal); // R5

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIMIT); // R5

  AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (count == '0)); // R6
endmodule

bind zero_run_detector zero_run_detector_chk #(.RUN_LOG2(RUN_LOG2)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit        (hit),
  .frame_edge (frame_edge),
  .count      (run_count),
  .no_signal  (no_signal_o)
);

// File: tb/test_zero_run_detector.sv
module test_zero_run_detector;
  localparam int unsigned RUN_LOG2 = 4;
  localparam int unsigned LIM      = 1 << RUN_LOG2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0;
  logic bclk = 1'b0;
  logic fclk = 1'b0;
  logic no_signal;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  int unsigned m_cnt = LIM;
  bit          m_prev_hit = 1'b0;

  always #5 clk = ~clk;

  zero_run_detector #(.RUN_LOG2(RUN_LOG2), .SYNC_STAGES(2)) i_zero_run_detector (
    .clk         (clk),
    .rst_n       (rst_n),
    .sdata_i     (sdata),
    .bclk_i      (bclk),
    .fclk_i      (fclk),
    .no_signal_o (no_signal)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: no_signal=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops queued expectations and compares with the flag.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) check(tag_q.pop_front(), no_signal, exp_q.pop_front());
    end
  end

  // Driver: one frame of 32 bits, MSB first, 2 cycles per bit clock phase.
  task automatic send_frame(input logic [31:0] bits, input logic [31:0] glitch,
                            input bit probe, input string req);
    if (!m_prev_hit && m_cnt < LIM) m_cnt++;
    m_prev_hit = 1'b0;
    if (|bits) begin
      m_cnt = 0;
      m_prev_hit = 1'b1;
    end
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      fclk  = (i < 16);
      bclk  = 1'b0;
      sdata = glitch[31-i] ? 1'b1 : bits[31-i];
      @(negedge clk);
      sdata = bits[31-i];
      @(negedge clk);
      bclk = 1'b1;
      if (probe && i == 0) begin
        repeat (2) @(posedge clk);
        #1 check("R3 before third edge", no_signal, 1'b1);
        @(posedge clk);
        #1 check("R3 at third edge", no_signal, 1'b0);
      end
      @(negedge clk);
    end
    @(negedge clk);
    bclk  = 1'b0;
    sdata = 1'b0;
    repeat (6) @(negedge clk);
    exp_q.push_back(m_cnt == LIM);
    tag_q.push_back(req);
  endtask

  task automatic zero_frames(input int n, input string req);
    for (int k = 0; k < n; k++) send_frame(32'h0, 32'h0, 1'b0, req);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", no_signal, 1'b1);
    zero_frames(3, "R1 high before first data");
    send_frame(32'h0, 32'h0F0F_0000, 1'b0, "R2 glitch between edges ignored");
    send_frame(32'h0001_0000, 32'h0, 1'b0, "R3 first data clears flag");
    zero_frames(LIM + 1, "R4 zero-run count");
    zero_frames(4, "R5 saturated flag holds");
    send_frame(32'h0, 32'hFFFF_FFFF, 1'b0, "R2 glitch while saturated");
    send_frame(32'h8000_0000, 32'h0, 1'b1, "R3 high bit drops flag");
    zero_frames(5, "R4 run building");
    send_frame(32'h0000_0001, 32'h0, 1'b0, "R6 single bit restarts run");
    zero_frames(LIM + 2, "R6 full run needed again");
    wait (exp_q.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule